// File: doc/BRIEF.md
# Infrared Frame Check Sequence Engine

This block computes the 16-bit frame check sequence used on slow-rate infrared links. Software drives it through a small register port. It writes a start bit to clear the engine. It then writes the frame bytes into a data register, one write per byte, and reads back two values: how many bytes were taken and the check value so far. Each accepted byte is folded into the running remainder in the cycle of its write, so writes may follow each other on every clock.

The arithmetic uses the generator x^16 + x^12 + x^5 + 1. Each byte is shifted in least significant bit first, which is the reflected form 0x8408. The remainder starts from all ones and is shown complemented. With these settings the start-up self-test gives a known answer: the bytes 0xCC, 0xF5, 0xF1, 0xA7 written after a clear read back a byte count of 4 and a check value of 0x51DF. Software clears the engine again before it is used for real traffic.

Top module: `sir_fcs_engine`

## Requirements
- R1: After the reset input, the count reads 0 and the check value (read address 2) reads 0x0000.
- R2: A write to address 0 with bit 15 set clears the count to 0 and restarts the remainder from 0xFFFF. The check value then reads 0x0000 again from the next cycle.
- R3: Bit 15 of address 0 always reads 0, and address 0 shows the count in bits 11:0 with zeros above. A write to address 0 with bit 15 clear changes neither the count nor the check value.
- R4: Each write to address 1 adds one to the count, and this holds when such writes come on consecutive cycles.
- R5: A write to address 1 folds bits 7:0 into the remainder, least significant bit first, with the reflected generator 0x8408. Address 2 reads the bitwise complement of the remainder.
- R6: Bits 15:8 of a write to address 1 have no effect on the check value.
- R7: After a clear, the inputs 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and a check value of 0x51DF.
- R8: The count stops at 0xFFF. Further writes to address 1 leave it at 0xFFF and still update the check value.
- R9: Reads are combinational on the read address. A read in the same cycle as a write shows the value from before that write, and the new value appears one cycle later.
- R10: Address 3 and address 1 read as 0. A write to address 3 changes neither the count nor the check value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| waddr | input | 2 | Write address: 0 control, 1 data, 2 check value |
| wdata | input | 16 | Write data |
| raddr | input | 2 | Read address |
| rdata | output | 16 | Read data for raddr |

## Verification
Two things can happen in the same cycle: a byte write to address 1, and a read of the count or the check value on the separate read address. The bench drives both together and expects the read to show the value from before the write; one cycle later it expects the updated value. Saturation of the count is a second coincidence. The bench writes 4095 bytes back to back and then more, and checks that the count holds at 0xFFF while the check value still follows the reference model for every byte.

// File: rtl/sir_fcs_engine.sv
module sir_fcs_engine #(
  parameter int          CNT_W  = 12,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY_R = 16'h8408,
  parameter logic [15:0] SEED   = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  waddr,
  input  logic [15:0] wdata,
  input  logic [1:0]  raddr,
  output logic [15:0] rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_SUM  = 2'd2;

  logic [15:0]      rem_q, rem_next;
  logic [CNT_W-1:0] cnt_q;

  wire restart  = wr_en && waddr == A_CTRL && wdata[15];
  wire take     = wr_en && waddr == A_DATA;
  wire saturate = cnt_q == CNT_MAX;

  always_comb begin
    rem_next = rem_q ^ {{(16-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
    for (int b = 0; b < BYTE_W; b++)
      rem_next = rem_next[0] ? ((rem_next >> 1) ^ POLY_R) : (rem_next >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= SEED;
      cnt_q <= '0;
    end else if (restart) begin
      rem_q <= SEED;
      cnt_q <= '0;
    end else if (take) begin
      rem_q <= rem_next;
      if (!saturate) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (raddr)
      A_CTRL:  rdata = 16'(cnt_q);
      A_SUM:   rdata = ~rem_q;
      default: rdata = '0;
    endcase
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && rem_q == SEED));
  assert_ctrl_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == A_CTRL && !wdata[15]) |=> ($stable(cnt_q) && $stable(rem_q)));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !saturate) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (saturate && !restart) |=> cnt_q == CNT_MAX);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !restart) |=> ($stable(cnt_q) && $stable(rem_q)));
endmodule

// File: tb/sir_fcs_engine_bench.sv
module sir_fcs_engine_bench;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] waddr = 0, raddr = 0;
  logic [15:0] wdata = 0, rdata;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_rem;
  int m_cnt;
  bit done = 0;

  sir_fcs_engine u_sir_fcs_engine (.clk, .rst_n, .wr_en, .waddr, .wdata, .raddr, .rdata);

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] fold(logic [15:0] r, logic [7:0] d);
    r ^= {8'h00, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1; waddr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    if (a == 2'd0 && d[15]) begin m_rem = 16'hFFFF; m_cnt = 0; end
    else if (a == 2'd1) begin
      m_rem = fold(m_rem, d[7:0]);
      if (m_cnt < 4095) m_cnt++;
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    raddr = a; #1; v = rdata;
  endtask

  task automatic expect_state(string req);
    logic [15:0] v;
    rd(2'd0, v); check(req, v, 16'(m_cnt));
    rd(2'd2, v); check(req, v, ~m_rem);
  endtask

  task automatic t_reset_state;
    logic [15:0] v;
    rd(2'd0, v); check("R1", v, 16'h0000);
    rd(2'd2, v); check("R1", v, 16'h0000);
  endtask

  task automatic t_selftest;
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R7", v, 16'd4);
    rd(2'd2, v); check("R7", v, 16'h51DF);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2", v, 16'h0000);
    rd(2'd2, v); check("R2", v, 16'h0000);
    rd(2'd0, v); check("R3", {v[15], 15'h0}, 16'h0000);
  endtask

  task automatic t_ctrl_noop;
    wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA);
    wr(2'd0, 16'h7FFF);
    expect_state("R3");
    wr(2'd3, 16'hFFFF);
    expect_state("R10");
  endtask

  task automatic t_bad_read;
    logic [15:0] v;
    rd(2'd3, v); check("R10", v, 16'h0000);
    rd(2'd1, v); check("R10", v, 16'h0000);
  endtask

  task automatic t_high_bits;
    logic [15:0] v, ref_sum;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h0012); wr(2'd1, 16'h0034);
    rd(2'd2, ref_sum);
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'hFF12); wr(2'd1, 16'h0A34);
    rd(2'd2, v); check("R6", v, ref_sum);
    rd(2'd0, v); check("R4", v, 16'd2);
  endtask

  task automatic t_patterns;
    logic [15:0] d;
    wr(2'd0, 16'h8000);
    for (int i = 0; i < 32; i++) begin
      d = 16'((i * 37 + 11) & 16'hFFFF);
      wr(2'd1, d);
    end
    expect_state("R5");
    wr(2'd1, 16'h0000); wr(2'd1, 16'h00FF);
    expect_state("R5");
  endtask

  task automatic t_same_cycle;
    logic [15:0] old_sum, v;
    int old_cnt;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h0033);
    old_sum = ~m_rem; old_cnt = m_cnt;
    wr_en = 1; waddr = 2'd1; wdata = 16'h00C7;
    raddr = 2'd2; #1; check("R9", rdata, old_sum);
    raddr = 2'd0; #1; check("R9", rdata, 16'(old_cnt));
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    m_rem = fold(m_rem, 8'hC7); m_cnt++;
    rd(2'd2, v); check("R9", v, ~m_rem);
    rd(2'd0, v); check("R9", v, 16'(m_cnt));
  endtask

  task automatic t_saturate;
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    for (int i = 0; i < 4095; i++) wr(2'd1, 16'(i & 255));
    rd(2'd0, v); check("R8", v, 16'h0FFF);
    wr(2'd1, 16'h005A); wr(2'd1, 16'h00E1);
    rd(2'd0, v); check("R8", v, 16'h0FFF);
    rd(2'd2, v); check("R8", v, ~m_rem);
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2", v, 16'h0000);
  endtask

  initial begin
    m_rem = 16'hFFFF; m_cnt = 0;
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_selftest();
    t_restart();
    t_ctrl_noop();
    t_bad_read();
    t_high_bits();
    t_patterns();
    t_same_cycle();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule